// File: doc/BRIEF.md
# Shared-Switch Multilevel Gate Sequencer

This block drives the eleven gate lines of a three-phase inverter. Each phase leg can be set to one of four levels (0 to 3 units of DC voltage). Two auxiliary bidirectional switches, X and Y, are common to all three legs. A modulator supplies up to three switching-level triplets per sampling period, one level for each phase, together with how many clock ticks each triplet is to be held. A one-cycle boundary pulse loads the set. The block then applies the triplets in order and turns each one into gate levels.

Because X and Y are shared, whether a triplet is legal depends on all three phases together. A triplet that asks for level 1 on one phase and level 2 on another would need both shared switches at once, which shorts the supply. Such a triplet switches every gate off and sets a fault that only reset clears. Whenever a transition turns some gates off and others on, the gates that are turning on wait for a programmable dead band.

Top module: `mlinv_gate_seq`

## Requirements
- R1: Gate bit order is: phase A upper = bit 0, A lower = 1, A auxiliary = 2; phase B uses bits 3..5 and phase C bits 6..8 in the same order; shared X = bit 9, shared Y = bit 10. Level 3 turns on only the upper switch, level 0 only the lower switch, and levels 1 and 2 turn on the auxiliary switch. No phase ever has more than one of its three gates on.
- R2: X is on exactly when some phase is at level 2, and Y is on exactly when some phase is at level 1. X and Y are never on together.
- R3: When an applied triplet has one phase at level 1 and another at level 2, all gates go off and `fault` rises, both on the edge where that triplet would otherwise appear.
- R4: Once set, `fault` stays high and all gates stay off until reset, whatever vectors are loaded afterwards.
- R5: During and after reset, all gates are off and `fault` is low, and they stay so until the first `period_start`.
- R6: Vector inputs are packed with vector i at `vec_state[6i+5:6i]` (A in the low two bits, then B, then C) and its dwell at `vec_dwell[16i+15:16i]`. The vectors are applied in index order. Each is held for its dwell in cycles, and a dwell of 0 counts as 1. Vector 0 reaches the gates on the edge after the one that samples `period_start`.
- R7: The last vector stays applied until the next `period_start`. Changes on `vec_state`, `vec_dwell` and `vec_count` have no effect unless `period_start` is high.
- R8: A period loaded with `vec_count` = 0 turns all gates off for that period.
- R9: When a change of gate pattern turns some gates off and others on, the falling gates drop at once. The rising gates come on `dead_cnt` cycles later than they would without a dead band. With `dead_cnt` = 0 there is no delay.
- R10: A change that only turns gates on, with none turning off, is applied at once for any `dead_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | Sampling-period boundary; loads the vector set |
| vec_state | input | 18 | Three level triplets, 2 bits per phase |
| vec_dwell | input | 48 | Dwell of each vector in clock cycles |
| vec_count | input | 2 | Number of vectors used in this period (0..3) |
| dead_cnt | input | 8 | Dead-band length in cycles |
| gate | output | 11 | Gate drive lines |
| fault | output | 1 | Sticky illegal-triplet flag |

## Verification
The bench aims at the edges of the schedule: zero dwells, where a design that skipped the vector or held it for 0 or 65536 cycles would slip every later vector, and the hold of the last vector, where a wrapping index would replay vector 0. It scrambles the vector inputs between boundaries, so a design that ignored `period_start` would change the gates mid-period. It steps a conflicting transition with a non-zero dead band and a first turn-on out of the all-off state. A design that failed to mask would briefly turn on opposing switches of one leg, and one that always delayed would lag on start-up. It also applies a triplet that needs both shared switches and then loads a legal period. A design without the sticky fault would let X and Y short the supply or resume switching.

// File: rtl/mlinv_pkg.sv
package mlinv_pkg;

    localparam int NPHASE = 3;
    localparam int NGATE  = 3 * NPHASE + 2;
    localparam int BIT_X  = 3 * NPHASE;
    localparam int BIT_Y  = 3 * NPHASE + 1;

    typedef logic [1:0] lvl_t;

    // One triplet: phase A in the low bits
    typedef struct packed {
        lvl_t c;
        lvl_t b;
        lvl_t a;
    } trip_t;

    typedef logic [NGATE-1:0] gates_t;

    // Per-leg pattern {aux, lower, upper}
    function automatic logic [2:0] leg_pattern(lvl_t s);
        case (s)
            2'd0:    return 3'b010;
            2'd3:    return 3'b001;
            default: return 3'b100;
        endcase
    endfunction

    // Level 1 needs Y and level 2 needs X; both together short the rail
    function automatic logic trip_legal(trip_t t);
        logic need_y;
        logic need_x;
        need_y = (t.a == 2'd1) || (t.b == 2'd1) || (t.c == 2'd1);
        need_x = (t.a == 2'd2) || (t.b == 2'd2) || (t.c == 2'd2);
        return !(need_y && need_x);
    endfunction

endpackage

// File: rtl/mlinv_vec_seq.sv
module mlinv_vec_seq
    import mlinv_pkg::*;
#(
    parameter int NVEC = 3,
    parameter int DW   = 16,
    localparam int CW  = $clog2(NVEC + 1),
    localparam int IW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 period_start,
    input  logic [NVEC*6-1:0]    vec_state,
    input  logic [NVEC*DW-1:0]   vec_dwell,
    input  logic [CW-1:0]        vec_count,
    output trip_t                cur_trip,
    output logic                 cur_valid
);

    trip_t           st_q [NVEC];
    logic [DW-1:0]   dw_q [NVEC];
    logic [CW-1:0]   cnt_q;
    logic [IW-1:0]   idx_q;
    logic [DW-1:0]   tick_q;
    logic            act_q;

    logic            dwell_done;
    logic            has_next;

    assign dwell_done = ({1'b0, tick_q} + (DW+1)'(1)) >= {1'b0, dw_q[idx_q]};
    assign has_next   = (int'(idx_q) + 1 < int'(cnt_q)) && (int'(idx_q) + 1 < NVEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NVEC; i++) begin
                st_q[i] <= '0;
                dw_q[i] <= '0;
            end
            cnt_q  <= '0;
            idx_q  <= '0;
            tick_q <= '0;
            act_q  <= 1'b0;
        end else if (period_start) begin
            for (int i = 0; i < NVEC; i++) begin
                st_q[i] <= trip_t'(vec_state[6*i +: 6]);
                dw_q[i] <= vec_dwell[DW*i +: DW];
            end
            cnt_q  <= vec_count;
            idx_q  <= '0;
            tick_q <= '0;
            act_q  <= (vec_count != '0);
        end else if (act_q && has_next) begin
            if (dwell_done) begin
                idx_q  <= idx_q + IW'(1);
                tick_q <= '0;
            end else begin
                tick_q <= tick_q + DW'(1);
            end
        end
    end

    assign cur_trip  = st_q[idx_q];
    assign cur_valid = act_q;

endmodule

// File: rtl/mlinv_gate_map.sv
module mlinv_gate_map
    import mlinv_pkg::*;
(
    input  trip_t   trip,
    input  logic    valid,
    output gates_t  target,
    output logic    illegal
);

    logic [2*NPHASE-1:0] lv;
    logic [NPHASE-1:0]   at_one;
    logic [NPHASE-1:0]   at_two;

    assign lv = trip;

    generate
        for (genvar p = 0; p < NPHASE; p++) begin : g_leg
            assign target[3*p +: 3] = valid ? leg_pattern(lv[2*p +: 2]) : 3'b000;
            assign at_one[p] = (lv[2*p +: 2] == 2'd1);
            assign at_two[p] = (lv[2*p +: 2] == 2'd2);
        end
    endgenerate

    assign target[BIT_X] = valid && (|at_two);
    assign target[BIT_Y] = valid && (|at_one);
    assign illegal       = valid && !trip_legal(trip);

endmodule

// File: rtl/mlinv_deadband.sv
module mlinv_deadband
    import mlinv_pkg::*;
#(
    parameter int DBW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  gates_t          target,
    input  logic            illegal,
    input  logic [DBW-1:0]  dead_cnt,
    output gates_t          gate,
    output logic            fault
);

    gates_t          gate_q;
    logic            fault_q;
    logic [DBW-1:0]  dbc_q;
    gates_t          falling;
    gates_t          rising;

    assign falling = gate_q & ~target;
    assign rising  = target & ~gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= '0;
            fault_q <= 1'b0;
            dbc_q   <= '0;
        end else if (fault_q || illegal) begin
            gate_q  <= '0;
            fault_q <= 1'b1;
            dbc_q   <= '0;
        end else if (dbc_q != '0) begin
            gate_q  <= gate_q & target;
            dbc_q   <= dbc_q - DBW'(1);
        end else if ((|falling) && (|rising) && (dead_cnt != '0)) begin
            gate_q  <= gate_q & target;
            dbc_q   <= dead_cnt - DBW'(1);
        end else begin
            gate_q  <= target;
        end
    end

    assign gate  = gate_q;
    assign fault = fault_q;

endmodule

// File: rtl/mlinv_gate_seq.sv
module mlinv_gate_seq
    import mlinv_pkg::*;
#(
    parameter int NVEC = 3,
    parameter int DW   = 16,
    parameter int DBW  = 8,
    localparam int CW  = $clog2(NVEC + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 period_start,
    input  logic [NVEC*6-1:0]    vec_state,
    input  logic [NVEC*DW-1:0]   vec_dwell,
    input  logic [CW-1:0]        vec_count,
    input  logic [DBW-1:0]       dead_cnt,
    output logic [NGATE-1:0]     gate,
    output logic                 fault
);

    trip_t   cur_trip;
    logic    cur_valid;
    gates_t  target;
    logic    illegal;

    mlinv_vec_seq #(.NVEC(NVEC), .DW(DW)) i_seq (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .vec_state    (vec_state),
        .vec_dwell    (vec_dwell),
        .vec_count    (vec_count),
        .cur_trip     (cur_trip),
        .cur_valid    (cur_valid)
    );

    mlinv_gate_map i_map (
        .trip    (cur_trip),
        .valid   (cur_valid),
        .target  (target),
        .illegal (illegal)
    );

    mlinv_deadband #(.DBW(DBW)) i_db (
        .clk      (clk),
        .rst      (rst),
        .target   (target),
        .illegal  (illegal),
        .dead_cnt (dead_cnt),
        .gate     (gate),
        .fault    (fault)
    );

endmodule

// File: rtl/mlinv_gate_seq_chk.sv
module mlinv_gate_seq_chk
    import mlinv_pkg::*;
#(
    parameter int DBW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NGATE-1:0]  gate,
    input logic              fault,
    input logic [DBW-1:0]    dead_cnt
);

    // R2: the shared pair never conducts together
    assert_no_shoot_R2: assert property (@(posedge clk) disable iff (rst)
        !(gate[BIT_X] && gate[BIT_Y]));

    // R1: at most one gate per leg
    assert_leg_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate[2:0]) && $onehot0(gate[5:3]) && $onehot0(gate[8:6]));

    // R4: fault is sticky
    assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R3: a faulted block drives nothing
    assert_fault_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        fault |-> (gate == '0));

    // R9: no simultaneous rise and fall unless the dead band is zero
    assert_dead_band_R9: assert property (@(posedge clk) disable iff (rst)
        ((|(gate & ~$past(gate))) && (|(~gate & $past(gate)))) |-> ($past(dead_cnt) == '0));

endmodule

bind mlinv_gate_seq mlinv_gate_seq_chk #(.DBW(DBW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .fault    (fault),
    .dead_cnt (dead_cnt)
);

// File: tb/test_mlinv_gate_seq.sv
`timescale 1ns/1ps
module test_mlinv_gate_seq;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         period_start = 1'b0;
    logic [17:0]  vec_state = '0;
    logic [47:0]  vec_dwell = '0;
    logic [1:0]   vec_count = '0;
    logic [7:0]   dead_cnt  = '0;
    logic [10:0]  gate;
    logic         fault;

    int checks = 0;
    int errors = 0;
    int cur_n;
    int cur_d [3];
    logic [5:0] cur_v [3];

    always #10 clk = ~clk;

    mlinv_gate_seq i_mlinv_gate_seq (
        .clk(clk), .rst(rst), .period_start(period_start),
        .vec_state(vec_state), .vec_dwell(vec_dwell), .vec_count(vec_count),
        .dead_cnt(dead_cnt), .gate(gate), .fault(fault)
    );

    function automatic logic [10:0] exp_gates(logic [5:0] t);
        logic [10:0] g = '0;
        for (int p = 0; p < 3; p++) begin
            case (t[2*p +: 2])
                2'd3: g[3*p]   = 1'b1;
                2'd0: g[3*p+1] = 1'b1;
                2'd2: begin g[3*p+2] = 1'b1; g[9]  = 1'b1; end
                default: begin g[3*p+2] = 1'b1; g[10] = 1'b1; end
            endcase
        end
        return g;
    endfunction

    function automatic logic legal_b(logic [5:0] t);
        logic one = 1'b0;
        logic two = 1'b0;
        for (int p = 0; p < 3; p++) begin
            if (t[2*p +: 2] == 2'd1) one = 1'b1;
            if (t[2*p +: 2] == 2'd2) two = 1'b1;
        end
        return !(one && two);
    endfunction

    // Index of the vector applied at schedule position pos
    function automatic int sched_idx(int pos);
        int i = 0;
        int acc = (cur_d[0] == 0) ? 1 : cur_d[0];
        while (pos >= acc && i < cur_n - 1) begin
            i++;
            acc += (cur_d[i] == 0) ? 1 : cur_d[i];
        end
        return i;
    endfunction

    task automatic chk(string req, logic [10:0] act, logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_period(int n);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            vec_state[6*i +: 6]   = cur_v[i];
            vec_dwell[16*i +: 16] = 16'(cur_d[i]);
        end
        vec_count    = 2'(n);
        cur_n        = n;
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        // R7: scramble the inputs; they must not matter now
        vec_state = 18'($urandom);
        vec_dwell = 48'({$urandom, $urandom});
        vec_count = 2'($urandom);
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) step();
        chk("R5 gates in reset", gate, '0);
        chk("R5 fault in reset", {10'd0, fault}, '0);
        rst = 1'b0;
        repeat (4) step();
        chk("R5 idle before first period", gate, '0);

        // R10 and R9: dead band of 3
        dead_cnt = 8'd3;
        cur_v[0] = 6'b00_00_00; cur_d[0] = 10;
        cur_v[1] = 6'b00_00_11; cur_d[1] = 10;
        cur_v[2] = 6'b00_00_00; cur_d[2] = 0;
        load_period(2);
        step();
        chk("R10 first turn-on not delayed", gate, exp_gates(cur_v[0]));
        for (int j = 2; j <= 10; j++) begin
            step();
            chk("R6 first vector held", gate, exp_gates(cur_v[0]));
        end
        for (int j = 11; j <= 13; j++) begin
            step();
            chk("R9 rising gates held off", gate, exp_gates(cur_v[0]) & exp_gates(cur_v[1]));
        end
        step();
        chk("R9 after dead band", gate, exp_gates(cur_v[1]));

        // Random legal periods without dead band
        dead_cnt = 8'd0;
        for (int per = 0; per < 25; per++) begin
            int n;
            int total;
            n = 1 + int'($urandom % 3);
            total = 0;
            for (int i = 0; i < 3; i++) begin
                logic [5:0] t;
                do t = 6'($urandom); while (!legal_b(t));
                cur_v[i] = t;
                cur_d[i] = int'($urandom % 7);
                if (i < n) total += (cur_d[i] == 0) ? 1 : cur_d[i];
            end
            if (per == 3) begin cur_d[0] = 0; cur_d[1] = 0; end
            load_period(n);
            for (int j = 1; j <= total + 3; j++) begin
                step();
                chk("R1 R2 R6 R7 schedule", gate, exp_gates(cur_v[sched_idx(j - 1)]));
            end
        end

        // R8: empty period
        load_period(0);
        for (int j = 1; j <= 3; j++) begin
            step();
            chk("R8 empty period", gate, '0);
        end

        // R3 and R4: illegal triplet
        cur_v[0] = 6'b11_11_11; cur_d[0] = 4;
        cur_v[1] = 6'b00_10_01; cur_d[1] = 4;
        load_period(2);
        for (int j = 1; j <= 4; j++) begin
            step();
            chk("R3 legal part before fault", gate, exp_gates(cur_v[0]));
        end
        chk("R3 fault low before", {10'd0, fault}, '0);
        step();
        chk("R3 gates off on illegal", gate, '0);
        chk("R3 fault raised", {10'd0, fault}, 11'd1);
        cur_v[0] = 6'b00_00_00; cur_d[0] = 3;
        load_period(1);
        for (int j = 1; j <= 5; j++) begin
            step();
            chk("R4 gates stay off", gate, '0);
            chk("R4 fault stays", {10'd0, fault}, 11'd1);
        end
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        chk("R5 fault cleared by reset", {10'd0, fault}, '0);
        chk("R5 gates off after reset", gate, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule